// File: doc/BRIEF.md
# Programmable Reset Supervisor Timer

This block generates the reset line of a board or subsystem from two digital supply flags. While either the supply-above-threshold flag or the power-on-ready flag is low, the reset is held active. Once both are high, the reset stays active for a programmable number of millisecond ticks and is then released. Firmware can also request a reset pulse through a register bit. That pulse has the same length, and the bit clears itself when the pulse ends. The block also returns a four-bit status word for a configuration register.

The output `rst_pull_o` controls an open-drain pad. A value of 1 pulls the line low, so reset is active. A value of 0 lets the line float high. The delay code is `TICKS_BASE << dly_sel_i` ticks. With the default base of 125, codes 00, 01, 10 and 11 give 125, 250, 500 and 1000 ms when one `tick_i` pulse arrives per millisecond.

The controller has three states:
- `ST_HOLD`: the supply is bad.
- `ST_COUNT`: the delay is running.
- `ST_RUN`: reset is released.

The transitions are:
- Any state goes to `ST_HOLD` when the supply is bad (drop).
- `ST_HOLD` goes to `ST_COUNT` when the supply is good (recover).
- `ST_COUNT` goes to `ST_RUN` on the tick that completes the delay (timeout).
- `ST_RUN` goes to `ST_COUNT` on a software request (soft start).

Top module: `rst_hold_supervisor`

## Requirements
- R1: While `rst_n` is low and right after it is released, `rst_pull_o` is 1 and status bit 3 (software-reset bit) is 0.
- R2: While `supply_ok_i` or `por_ready_i` is 0, `rst_pull_o` is 1 from the next clock edge on, whatever the tick input does.
- R3: After both supply flags are high, the first edge enters counting. `rst_pull_o` is released at the edge that samples the `TICKS_BASE << dly_sel_i`-th tick after that edge (codes 00, 01, 10, 11 give 1x, 2x, 4x, 8x the base).
- R4: Only cycles with `tick_i` high advance the delay; without ticks, reset stays active indefinitely.
- R5: `swrst_set_i` high in the released state starts the same timed reset. Status bit 3 reads 1 for the whole pulse and returns to 0 at the release edge. A request made while reset is already active has no effect and leaves bit 3 at 0.
- R6: Status bit 2 equals `rst_pull_o` in every cycle.
- R7: Status bit 0 mirrors `por_ready_i` and status bit 1 mirrors `supply_ok_i`, combinationally.
- R8: If the supply goes bad during the delay, the delay restarts from zero after recovery and runs its full length.
- R9: `dly_sel_i` is sampled when a delay starts; changing it during the delay does not change that delay's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset |
| supply_ok_i | input | 1 | Supply above trip threshold |
| por_ready_i | input | 1 | Supply past power-on level |
| tick_i | input | 1 | One-cycle millisecond enable |
| dly_sel_i | input | 2 | Delay code from register bank |
| swrst_set_i | input | 1 | Software reset request write |
| rst_pull_o | output | 1 | 1 = pull reset line low |
| stat_o | output | 4 | {sw bit, reset active, trip, ready} |

## Verification
The state register is the only register between the inputs and `rst_pull_o`. A supply drop or a software request is therefore visible one edge after it is sampled. The release is visible at the edge that samples the last tick, counting the entry edge as the first. The bench therefore expects reset for exactly `(TICKS_BASE << code) + 1` samples when a tick arrives every cycle. It samples 1 ns after each rising edge and drives inputs on falling edges.

The status mirror bits are combinational and are checked in the same cycle their inputs change. The bench sweeps every delay code, every supply flag pair and every drop point inside one delay, using a base of 3 ticks.

// File: rtl/rhs_pkg.sv
package rhs_pkg;
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_COUNT = 2'd1,
        ST_RUN   = 2'd2
    } rhs_state_e;
endpackage

// File: rtl/rhs_delay_cnt.sv
module rhs_delay_cnt #(
    parameter int TICKS_BASE = 125,
    parameter int SEL_W      = 2,
    localparam int MAX_TICKS = TICKS_BASE << ((1 << SEL_W) - 1),
    localparam int CNT_W     = $clog2(MAX_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_q;
    logic [CNT_W-1:0] base_c;

    assign base_c = CNT_W'(TICKS_BASE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= base_c;
        end else if (start_i) begin
            cnt_q <= '0;
            lim_q <= base_c << sel_i;
        end else if (run_i) begin
            if (tick_i) cnt_q <= cnt_q + CNT_W'(1);
        end else begin
            cnt_q <= '0;
        end
    end

    assign done_o = run_i && tick_i && (cnt_q == lim_q - CNT_W'(1));

    // R3: the count never passes the latched limit while running
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < lim_q));

    // R9: limit only changes when a new delay starts
    p_lim_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(lim_q));
endmodule

// File: rtl/rhs_status.sv
module rhs_status (
    input  logic       por_ready_i,
    input  logic       supply_ok_i,
    input  logic       rst_active_i,
    input  logic       sw_bit_i,
    output logic [3:0] stat_o
);
    assign stat_o = {sw_bit_i, rst_active_i, supply_ok_i, por_ready_i};
endmodule

// File: rtl/rst_hold_supervisor.sv
module rst_hold_supervisor #(
    parameter int TICKS_BASE = 125,
    parameter int SEL_W      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_ok_i,
    input  logic             por_ready_i,
    input  logic             tick_i,
    input  logic [SEL_W-1:0] dly_sel_i,
    input  logic             swrst_set_i,
    output logic             rst_pull_o,
    output logic [3:0]       stat_o
);
    import rhs_pkg::*;

    rhs_state_e state_q, state_d;
    logic       good;
    logic       start;
    logic       run;
    logic       done;
    logic       sw_q;
    logic       soft_go;

    assign good    = supply_ok_i && por_ready_i;
    assign soft_go = (state_q == ST_RUN) && good && swrst_set_i;
    assign start   = ((state_q == ST_HOLD) && good) || soft_go;
    assign run     = (state_q == ST_COUNT) && good;

    rhs_delay_cnt #(.TICKS_BASE(TICKS_BASE), .SEL_W(SEL_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start),
        .run_i  (run),
        .tick_i (tick_i),
        .sel_i  (dly_sel_i),
        .done_o (done)
    );

    always_comb begin
        state_d = state_q;
        if (!good) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_HOLD:  state_d = ST_COUNT;
                ST_COUNT: if (done) state_d = ST_RUN;
                ST_RUN:   if (swrst_set_i) state_d = ST_COUNT;
                default:  state_d = ST_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            sw_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (soft_go)   sw_q <= 1'b1;
            else if (done) sw_q <= 1'b0;
        end
    end

    always_comb begin
        rst_pull_o = (state_q != ST_RUN);
    end

    rhs_status u_stat (
        .por_ready_i (por_ready_i),
        .supply_ok_i (supply_ok_i),
        .rst_active_i(rst_pull_o),
        .sw_bit_i    (sw_q),
        .stat_o      (stat_o)
    );

    // R2: a bad supply forces reset at the next edge
    p_hold_on_bad_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !good |=> rst_pull_o);

    // R4: release only happens on a sampled tick
    p_release_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_pull_o) |-> $past(tick_i));

    // R5: software bit is only set while reset is active
    p_sw_bit_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sw_q |-> rst_pull_o);

    // R5: software bit clears together with the release
    p_sw_clear_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_q) |-> !rst_pull_o);
endmodule

// File: tb/rst_hold_supervisor_tb.sv
module rst_hold_supervisor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       supply_ok_i, por_ready_i, tick_i, swrst_set_i;
    logic [1:0] dly_sel_i;
    logic       rst_pull_o;
    logic [3:0] stat_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_hold_supervisor #(.TICKS_BASE(BASE), .SEL_W(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok_i),
        .por_ready_i(por_ready_i), .tick_i(tick_i), .dly_sel_i(dly_sel_i),
        .swrst_set_i(swrst_set_i), .rst_pull_o(rst_pull_o), .stat_o(stat_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Samples after each edge until release; returns reset length in samples.
    task automatic measure(input string req, input int exp, input bit sw,
                           input int new_sel);
        int  n = 0;
        bit  stat_bad = 0;
        bit  sw_bad = 0;
        while (n < 400) begin
            @(posedge clk); #1;
            n++;
            if (n == 1) begin
                swrst_set_i = 1'b0;
                if (new_sel >= 0) dly_sel_i = new_sel[1:0];
            end
            if (stat_o[2] != rst_pull_o) stat_bad = 1;
            if (rst_pull_o && (stat_o[3] != sw)) sw_bad = 1;
            if (!rst_pull_o) break;
        end
        check({req, " length"}, n, exp);
        check("R6 stat bit2 tracks reset", stat_bad, 0);
        check("R5 sw bit during pulse", sw_bad, 0);
        check("R5 sw bit after release", stat_o[3], 0);
    endtask

    task automatic go_bad();
        @(negedge clk);
        supply_ok_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; supply_ok_i = 0; por_ready_i = 0; tick_i = 0;
        swrst_set_i = 0; dly_sel_i = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset asserted in reset", rst_pull_o, 1);
        check("R1 sw bit zero", stat_o[3], 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 reset asserted after release", rst_pull_o, 1);

        // R7 and R2: every flag pair except both good
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            supply_ok_i = c[1]; por_ready_i = c[0]; tick_i = 1'b1;
            #1;
            check("R7 ready bit", stat_o[0], c[0]);
            check("R7 trip bit", stat_o[1], c[1]);
            if (c != 3) begin
                repeat (20) @(posedge clk);
                #1;
                check("R2 held while bad", rst_pull_o, 1);
            end
        end
        go_bad();

        // R3: every delay code after supply recovery
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            dly_sel_i = s[1:0]; supply_ok_i = 1; por_ready_i = 1;
            measure("R3 power-up", (BASE << s) + 1, 0, -1);
            go_bad();
            #1;
            check("R2 drop reasserts", rst_pull_o, 1);
        end

        // R4: no ticks, no progress
        @(negedge clk);
        tick_i = 0; dly_sel_i = 2'd1; supply_ok_i = 1; por_ready_i = 1;
        repeat (40) @(posedge clk);
        #1;
        check("R4 held without ticks", rst_pull_o, 1);
        @(negedge clk); tick_i = 1;
        measure("R4 resumed", BASE << 1, 0, -1);

        // R5: software pulse for every code
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            dly_sel_i = s[1:0]; swrst_set_i = 1;
            measure("R5 soft pulse", (BASE << s) + 1, 1, -1);
        end
        // R5: request while reset active is ignored
        go_bad();
        @(negedge clk); swrst_set_i = 1;
        repeat (3) @(posedge clk);
        #1;
        check("R5 request in hold ignored", stat_o[3], 0);
        @(negedge clk); swrst_set_i = 0; dly_sel_i = 0; supply_ok_i = 1;
        measure("R5 recovery", BASE + 1, 0, -1);

        // R8: drop at every point inside a delay
        for (int d = 1; d < (BASE << 1); d++) begin
            go_bad();
            @(negedge clk); dly_sel_i = 2'd1; supply_ok_i = 1;
            repeat (d) @(posedge clk);
            @(negedge clk); supply_ok_i = 0;
            @(negedge clk); supply_ok_i = 1;
            measure("R8 restart", (BASE << 1) + 1, 0, -1);
        end

        // R9: code change during a delay has no effect
        go_bad();
        @(negedge clk); dly_sel_i = 2'd0; supply_ok_i = 1;
        measure("R9 sel sampled at start", BASE + 1, 0, 3);
        @(negedge clk); swrst_set_i = 1; dly_sel_i = 2'd2;
        measure("R9 soft sel sampled", (BASE << 2) + 1, 1, 0);

        done_flag = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done_flag) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule